// File: doc/BRIEF.md
# Windowed Watchdog with Early Warning

This block watches software health with a 7-bit down counter that software must reload inside a time window. The counter ticks at the bus clock divided by a fixed base divider (4096 by default) and by a selectable 1, 2, 4 or 8. Once software starts the watchdog, a reload that comes too early (counter still above the programmed window value) or too late (counter decayed below 0x40) produces a one-cycle reset pulse for the system reset controller.

An early-warning flag is set as the counter reaches 0x40, one tick before the timeout. Its interrupt output is masked by an enable bit. Software uses this warning to save state or to reload at the last legal moment. Everything is driven through a single write port with three registers: control (start bit and counter), configuration (window, time base, warning enable) and warning status.

Top module: `wwdg_top`

## Requirements
- R1: After rst_ni the watchdog is stopped, wdg_rst_o and early_irq_o are low, the window is 0x7F, the time-base select is 0 and the warning interrupt is disabled.
- R2: A control write (address 0) loads the counter from data[6:0]. data[7]=1 starts the watchdog. A control write with data[7]=0 does not stop a running watchdog; only rst_ni stops it.
- R3: While running and not frozen, the counter decrements once every BASE_DIV*2^tb clocks, where tb is configuration data[8:7]. Every control write restarts the divider, so the first decrement comes that many clocks after the write.
- R4: When a decrement takes the counter from 0x40 to 0x3F, wdg_rst_o is high in the cycle after that clock edge.
- R5: A control write while running, with the counter at that moment greater than the window (configuration data[6:0], address 1), fires the reset in the cycle after the write. A counter equal to or below the window is a legal reload.
- R6: A control write with data[6]=0 that leaves the watchdog running (already running or started by this write) fires the reset at once.
- R7: wdg_rst_o is a single-cycle pulse. After it fires, the counter freezes and no further timeout occurs until the next control write, which resumes counting.
- R8: The warning flag sets when a decrement takes the counter from 0x41 to 0x40. early_irq_o equals the flag ANDed with the enable bit (configuration data[9]).
- R9: The warning flag is sticky. Only a status write (address 2) with data[0]=0, or rst_ni, clears it. A status write with data[0]=1 leaves it unchanged.
- R10: While the watchdog is stopped, the counter never decrements and no reset is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 control, 1 configuration, 2 status, 3 unused |
| wr_data_i | input | 10 | Write data |
| wdg_rst_o | output | 1 | Single-cycle watchdog reset pulse |
| early_irq_o | output | 1 | Early-warning interrupt |

## Verification
The bench builds the block with BASE_DIV=4 and keeps TB_W=2. A tick then lasts 4 to 32 clocks, so each timeout, warning edge and all four time-base selects can be reached in a few hundred cycles. With this divider the bench can place reloads on exact tick boundaries. It checks the window boundary at counter values equal to the window and one above it, and it measures timeout and warning latencies to the exact cycle.

// File: rtl/wwdg_pkg.sv
package wwdg_pkg;
  localparam int CNT_W = 7;
  localparam logic [CNT_W-1:0] CNT_FLOOR = 7'h40;
  localparam logic [CNT_W-1:0] CNT_WARN  = 7'h41;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CFG  = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  // bit layout matches configuration write data
  typedef struct packed {
    logic             ewi_en;
    logic [1:0]       tbase;
    logic [CNT_W-1:0] win;
  } cfg_t;

  localparam int DATA_W = $bits(cfg_t);
endpackage

// File: rtl/wwdg_prescale.sv
module wwdg_prescale #(
  parameter int BASE_DIV = 4096,
  parameter int TB_W     = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            clr_i,
  input  logic [TB_W-1:0] tbase_i,
  output logic            tick_o
);
  localparam int MAX_SH = (1 << TB_W) - 1;
  localparam int DIV_W  = $clog2(BASE_DIV + 1) + MAX_SH + 1;

  logic [DIV_W-1:0] div_q, limit;

  always_comb limit = (DIV_W'(BASE_DIV) << tbase_i) - DIV_W'(1);

  assign tick_o = en_i && (div_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            div_q <= '0;
    else if (clr_i || !en_i) div_q <= '0;
    else if (tick_o)        div_q <= '0;
    else                    div_q <= div_q + DIV_W'(1);
  end
endmodule

// File: rtl/wwdg_regs.sv
module wwdg_regs
  import wwdg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              warn_i,
  output cfg_t              cfg_o,
  output logic              flag_o,
  output logic              ctrl_wr_o
);
  cfg_t cfg_q;
  logic flag_q;
  reg_addr_e addr;

  assign addr      = reg_addr_e'(wr_addr_i);
  assign ctrl_wr_o = wr_en_i && (addr == ADDR_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{ewi_en: 1'b0, tbase: 2'd0, win: 7'h7F};
    end else if (wr_en_i && addr == ADDR_CFG) begin
      cfg_q <= cfg_t'(wr_data_i);
    end
  end

  // set wins over a clearing write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                           flag_q <= 1'b0;
    else if (warn_i)                                       flag_q <= 1'b1;
    else if (wr_en_i && addr == ADDR_STAT && !wr_data_i[0]) flag_q <= 1'b0;
  end

  assign cfg_o  = cfg_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/wwdg_core.sv
module wwdg_core
  import wwdg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_wr_i,
  input  logic [CNT_W:0]   ctrl_data_i,
  input  logic [CNT_W-1:0] win_i,
  input  logic             tick_i,
  output logic             fire_o,
  output logic             warn_o,
  output logic             active_o,
  output logic             halted_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic active_q, active_d, halt_q, halt_d, fire_q, fire_d, warn_d;

  always_comb begin
    cnt_d    = cnt_q;
    active_d = active_q;
    halt_d   = halt_q;
    fire_d   = 1'b0;
    warn_d   = 1'b0;
    if (ctrl_wr_i) begin
      cnt_d    = ctrl_data_i[CNT_W-1:0];
      active_d = active_q | ctrl_data_i[CNT_W];
      halt_d   = 1'b0;
      if (active_q && (cnt_q > win_i))            fire_d = 1'b1; // reload too early
      if (active_d && !ctrl_data_i[CNT_W-1])      fire_d = 1'b1; // loaded below floor
    end else if (tick_i) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNT_FLOOR) fire_d = 1'b1;
      if (cnt_q == CNT_WARN)  warn_d = 1'b1;
    end
    if (fire_d) halt_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '1;
      active_q <= 1'b0;
      halt_q   <= 1'b0;
      fire_q   <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      active_q <= active_d;
      halt_q   <= halt_d;
      fire_q   <= fire_d;
    end
  end

  assign fire_o   = fire_q;
  assign warn_o   = warn_d;
  assign active_o = active_q;
  assign halted_o = halt_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/wwdg_top.sv
module wwdg_top
  import wwdg_pkg::*;
#(
  parameter int BASE_DIV = 4096,
  parameter int TB_W     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wdg_rst_o,
  output logic              early_irq_o
);
  cfg_t             cfg;
  logic             flag, ctrl_wr, tick, warn, active, halted;
  logic [CNT_W-1:0] cnt;

  wwdg_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .warn_i    (warn),
    .cfg_o     (cfg),
    .flag_o    (flag),
    .ctrl_wr_o (ctrl_wr)
  );

  wwdg_prescale #(.BASE_DIV(BASE_DIV), .TB_W(TB_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (active && !halted),
    .clr_i   (ctrl_wr),
    .tbase_i (cfg.tbase[TB_W-1:0]),
    .tick_o  (tick)
  );

  wwdg_core u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_wr_i   (ctrl_wr),
    .ctrl_data_i (wr_data_i[CNT_W:0]),
    .win_i       (cfg.win),
    .tick_i      (tick),
    .fire_o      (wdg_rst_o),
    .warn_o      (warn),
    .active_o    (active),
    .halted_o    (halted),
    .cnt_o       (cnt)
  );

  assign early_irq_o = flag && cfg.ewi_en;
endmodule

// File: rtl/wwdg_chk.sv
module wwdg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wdg_rst_i,
  input logic       irq_i,
  input logic       ewi_en_i,
  input logic       active_i,
  input logic       halted_i,
  input logic       ctrl_wr_i,
  input logic       tick_i,
  input logic [6:0] cnt_i
);
  assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdg_rst_i |=> !wdg_rst_i);

  assert_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_i && !ctrl_wr_i) |=> $stable(cnt_i));

  assert_rst_needs_active_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdg_rst_i |-> active_i);

  assert_active_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |=> active_i);

  assert_irq_masked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> ewi_en_i);

  assert_decrement_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ctrl_wr_i) |=> (cnt_i == $past(cnt_i) - 7'd1));

  assert_stopped_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && !ctrl_wr_i) |=> $stable(cnt_i));
endmodule

bind wwdg_top wwdg_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wdg_rst_i (wdg_rst_o),
  .irq_i     (early_irq_o),
  .ewi_en_i  (cfg.ewi_en),
  .active_i  (active),
  .halted_i  (halted),
  .ctrl_wr_i (ctrl_wr),
  .tick_i    (tick),
  .cnt_i     (cnt)
);

// File: tb/wwdg_top_tb_top.sv
module wwdg_top_tb_top;
  localparam int BASE = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = 2'd0;
  logic [9:0] wr_data_i = '0;
  logic       wdg_rst_o, early_irq_o;

  int n_chk = 0;
  int n_fail = 0;
  int m_rst, m_irq, m_pulses;

  always #10 clk_i = ~clk_i;

  wwdg_top #(.BASE_DIV(BASE), .TB_W(2)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .wdg_rst_o   (wdg_rst_o),
    .early_irq_o (early_irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sys_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [9:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // k counts clock edges after the last write edge
  task automatic measure(input int cycles);
    m_rst = -1; m_irq = -1; m_pulses = 0;
    for (int k = 1; k <= cycles; k++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      if (wdg_rst_o) begin
        m_pulses++;
        if (m_rst < 0) m_rst = k;
      end
      if (early_irq_o && m_irq < 0) m_irq = k;
    end
  endtask

  task automatic t_reset_state();
    sys_reset();
    chk("R1 rst low", int'(wdg_rst_o), 0);
    chk("R1 irq low", int'(early_irq_o), 0);
    measure(300);
    chk("R10 no reset while stopped", m_pulses, 0);
    wr(2'd0, 10'h041);
    measure(100);
    chk("R10 no decay when stopped", m_pulses, 0);
  endtask

  task automatic t_timeout();
    sys_reset();
    wr(2'd1, 10'h27F);
    wr(2'd0, 10'h0C5);
    measure(40);
    chk("R8 warning latency", m_irq, 20);
    chk("R4 R3 timeout latency", m_rst, 24);
    chk("R7 single pulse", m_pulses, 1);
    measure(100);
    chk("R7 frozen no more resets", m_pulses, 0);
    chk("R9 flag sticky", int'(early_irq_o), 1);
    wr(2'd0, 10'h0C5);
    chk("R7 reload after freeze legal", int'(wdg_rst_o), 0);
    measure(30);
    chk("R7 resumed timeout", m_rst, 24);
  endtask

  task automatic t_timebase();
    sys_reset();
    wr(2'd1, 10'h17F);
    wr(2'd0, 10'h0C2);
    measure(60);
    chk("R3 tb=2 timeout", m_rst, 48);
    chk("R8 irq masked", m_irq, -1);
    wr(2'd1, 10'h37F);
    chk("R8 flag set while masked", int'(early_irq_o), 1);
    wr(2'd2, 10'h001);
    chk("R9 write one keeps flag", int'(early_irq_o), 1);
    wr(2'd2, 10'h000);
    chk("R9 write zero clears", int'(early_irq_o), 0);
    sys_reset();
    wr(2'd1, 10'h1FF);
    wr(2'd0, 10'h0C1);
    measure(70);
    chk("R3 tb=3 timeout", m_rst, 64);
  endtask

  task automatic t_window();
    sys_reset();
    wr(2'd1, 10'h050);
    wr(2'd0, 10'h0FF);
    chk("R5 first start no window check", int'(wdg_rst_o), 0);
    wr(2'd0, 10'h0FF);
    chk("R5 early reload resets", int'(wdg_rst_o), 1);
    sys_reset();
    wr(2'd1, 10'h050);
    wr(2'd0, 10'h0D2);
    repeat (8) @(posedge clk_i);
    @(negedge clk_i);
    wr(2'd0, 10'h0D2);
    chk("R5 reload at window legal", int'(wdg_rst_o), 0);
    repeat (4) @(posedge clk_i);
    @(negedge clk_i);
    wr(2'd0, 10'h0D2);
    chk("R5 reload one above window", int'(wdg_rst_o), 1);
  endtask

  task automatic t_low_load();
    sys_reset();
    wr(2'd0, 10'h0C5);
    wr(2'd0, 10'h085);
    chk("R6 load below floor running", int'(wdg_rst_o), 1);
    sys_reset();
    wr(2'd0, 10'h090);
    chk("R6 start with floor bit clear", int'(wdg_rst_o), 1);
  endtask

  task automatic t_activation();
    sys_reset();
    wr(2'd0, 10'h0C3);
    wr(2'd0, 10'h043);
    chk("R2 clear bit ignored no reset", int'(wdg_rst_o), 0);
    measure(20);
    chk("R2 still running", m_rst, 16);
    sys_reset();
    wr(2'd0, 10'h041);
    measure(50);
    chk("R2 stopped by system reset", m_pulses, 0);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_timeout();
    t_timebase();
    t_window();
    t_low_load();
    t_activation();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule